// File: doc/BRIEF.md
# Banked Data Memory Address Generator

This block turns the 8-bit register field of an instruction into a 12-bit physical address for a 4 KB data space. The space is made up of 16 banks of 256 bytes. Bank n covers addresses n00h to nFFh.

A one-bit mode operand selects one of two mappings.

- **Window mode (mode 0, the default).** Field values below 0x80 reach the bottom 128 bytes of RAM. Values of 0x80 and above reach the special-function area at 0xF80–0xFFF. In that area the working register sits at 0xFE8.
- **Banked mode (mode 1).** A bank register supplies the top four address bits and the field supplies the low eight.

The bank register is written by a load strobe that carries an 8-bit literal. Only the low four bits of the literal are kept. The upper nibble always reads back as zero. A load made in one cycle governs banked accesses from the next cycle on. The address output is combinational from the field, the mode bit and the current register value.

Every pin is a plain control or status signal. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `bdm_addr_gen`

## Requirements
- R1: After reset the bank register reads 0x00, so a banked access with field F yields address 0x0FF-masked {4'h0, F}.
- R2: With mode 0 and field F < 0x80, the address is {4'h0, F} (0x000–0x07F) whatever the bank register holds.
- R3: With mode 0 and field F >= 0x80, the address is {4'hF, F} (0xF80–0xFFF); field 0xE8 yields 0xFE8.
- R4: With mode 1, the address is {bank[3:0], F}: bits 11:8 come from the bank register, bits 7:0 from the field.
- R5: A load strobe high at a rising clock edge stores the literal. During the cycle of the strobe, addresses still use the old bank; from the next cycle on they use the new one.
- R6: Bits 7:4 of the bank read-back are always zero, and literal bits 7:4 are discarded on a load.
- R7: Without a load strobe the bank register keeps its value across clock edges.
- R8: The bank register has no effect on mode-0 addresses: the same field gives the same window address under any bank value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| fld_i | input | 8 | Register field of the instruction |
| bank_mode_i | input | 1 | 0 = fixed window, 1 = banked |
| bank_ld_i | input | 1 | Load strobe for the bank register |
| bank_lit_i | input | 8 | Literal for the load; bits 7:4 are discarded |
| bank_rb_o | output | 8 | Bank register read-back, upper nibble zero |
| addr_o | output | 12 | Physical data address |

## Verification
The assertions check the following on every clocked cycle:
- the register read-back keeps a zero upper nibble;
- a load lands one cycle after its strobe;
- the register holds when no strobe is present;
- the address follows the banked or window mapping that the mode bit selects.

Only the bench scenarios can show the following:
- the exact boundary values 0x7F/0x80 and the working-register address 0xFE8;
- that a load cycle still addresses the old bank;
- that window addresses stay fixed when the bank changes between accesses.

// File: rtl/bdm_pkg.sv
package bdm_pkg;
  localparam int FIELD_W = 8;
  localparam int BANK_W  = 4;
  localparam int REG_W   = 8;
  localparam int ADDR_W  = FIELD_W + BANK_W;

  typedef enum logic {
    MODE_WINDOW = 1'b0,
    MODE_BANKED = 1'b1
  } addr_mode_e;
endpackage

// File: rtl/bdm_bank_reg.sv
module bdm_bank_reg #(
  parameter int BANK_W = 4,
  parameter int REG_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_i,
  input  logic [REG_W-1:0] lit_i,
  output logic [BANK_W-1:0] bank_o,
  output logic [REG_W-1:0]  rb_o
);
  localparam int PAD_W = REG_W - BANK_W;

  logic [BANK_W-1:0] bank_q;

  // only the low nibble is stored; upper literal bits are dropped
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    bank_q <= '0;
    else if (ld_i) bank_q <= lit_i[BANK_W-1:0];
  end

  assign bank_o = bank_q;

  generate
    if (PAD_W > 0) begin : g_pad
      assign rb_o = {{PAD_W{1'b0}}, bank_q};
    end else begin : g_nopad
      assign rb_o = bank_q[REG_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/bdm_window_map.sv
module bdm_window_map #(
  parameter int FIELD_W = 8,
  parameter int ADDR_W  = 12,
  parameter int SPLIT   = 128
) (
  input  logic [FIELD_W-1:0] fld_i,
  output logic [ADDR_W-1:0]  addr_o
);
  localparam int HI_W = ADDR_W - FIELD_W;

  logic upper_half;

  // low field values reach the bottom of RAM, high ones the top page
  assign upper_half = (int'(fld_i) >= SPLIT);
  assign addr_o = {{HI_W{upper_half}}, fld_i};
endmodule

// File: rtl/bdm_addr_select.sv
module bdm_addr_select #(
  parameter int FIELD_W = 8,
  parameter int BANK_W  = 4,
  parameter int ADDR_W  = 12
) (
  input  bdm_pkg::addr_mode_e mode_i,
  input  logic [FIELD_W-1:0]  fld_i,
  input  logic [BANK_W-1:0]   bank_i,
  input  logic [ADDR_W-1:0]   win_addr_i,
  output logic [ADDR_W-1:0]   addr_o
);
  always_comb begin
    unique case (mode_i)
      bdm_pkg::MODE_BANKED: addr_o = {bank_i, fld_i};
      default:              addr_o = win_addr_i;
    endcase
  end
endmodule

// File: rtl/bdm_addr_gen.sv
module bdm_addr_gen
  import bdm_pkg::*;
#(
  parameter int SPLIT = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FIELD_W-1:0] fld_i,
  input  logic              bank_mode_i,
  input  logic              bank_ld_i,
  input  logic [REG_W-1:0]  bank_lit_i,
  output logic [REG_W-1:0]  bank_rb_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic [BANK_W-1:0] bank_cur;
  logic [ADDR_W-1:0] win_addr;
  addr_mode_e        mode;

  assign mode = addr_mode_e'(bank_mode_i);

  bdm_bank_reg #(.BANK_W(BANK_W), .REG_W(REG_W)) u_reg (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld_i   (bank_ld_i),
    .lit_i  (bank_lit_i),
    .bank_o (bank_cur),
    .rb_o   (bank_rb_o)
  );

  bdm_window_map #(.FIELD_W(FIELD_W), .ADDR_W(ADDR_W), .SPLIT(SPLIT)) u_win (
    .fld_i  (fld_i),
    .addr_o (win_addr)
  );

  bdm_addr_select #(.FIELD_W(FIELD_W), .BANK_W(BANK_W), .ADDR_W(ADDR_W)) u_sel (
    .mode_i     (mode),
    .fld_i      (fld_i),
    .bank_i     (bank_cur),
    .win_addr_i (win_addr),
    .addr_o     (addr_o)
  );
endmodule

// File: rtl/bdm_addr_gen_chk.sv
module bdm_addr_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  fld_i,
  input logic        bank_mode_i,
  input logic        bank_ld_i,
  input logic [7:0]  bank_lit_i,
  input logic [7:0]  bank_rb_o,
  input logic [11:0] addr_o
);
  AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |-> bank_rb_o == 8'h00); // R1
  AST_WINDOW_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!bank_mode_i && fld_i < 8'h80) |-> addr_o == {4'h0, fld_i}); // R2
  AST_WINDOW_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!bank_mode_i && fld_i >= 8'h80) |-> addr_o == {4'hF, fld_i}); // R3
  AST_BANKED_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    bank_mode_i |-> addr_o == {bank_rb_o[3:0], fld_i}); // R4
  AST_LOAD_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    bank_ld_i |=> bank_rb_o == {4'h0, $past(bank_lit_i[3:0])}); // R5
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bank_rb_o[7:4] == 4'h0); // R6
  AST_HOLD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_ld_i |=> $stable(bank_rb_o)); // R7
endmodule

bind bdm_addr_gen bdm_addr_gen_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .fld_i       (fld_i),
  .bank_mode_i (bank_mode_i),
  .bank_ld_i   (bank_ld_i),
  .bank_lit_i  (bank_lit_i),
  .bank_rb_o   (bank_rb_o),
  .addr_o      (addr_o)
);

// File: tb/sim_bdm_addr_gen.sv
`timescale 1ns/1ps
module sim_bdm_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  fld_i = 8'h00;
  logic        bank_mode_i = 1'b0;
  logic        bank_ld_i = 1'b0;
  logic [7:0]  bank_lit_i = 8'h00;
  logic [7:0]  bank_rb_o;
  logic [11:0] addr_o;

  int checks = 0;
  int errors = 0;
  logic [3:0] mdl_bank = 4'h0;

  typedef struct {
    logic [11:0] addr;
    logic [7:0]  rb;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  event drv_ev;

  always #5 clk = ~clk;

  bdm_addr_gen u0 (
    .clk(clk), .rst_n(rst_n), .fld_i(fld_i), .bank_mode_i(bank_mode_i),
    .bank_ld_i(bank_ld_i), .bank_lit_i(bank_lit_i),
    .bank_rb_o(bank_rb_o), .addr_o(addr_o)
  );

  // Expected address from the requirements: R2/R3 window mode, R4 banked mode.
  function automatic logic [11:0] model_addr(logic m, logic [7:0] f);
    if (m) return {mdl_bank, f};
    return (f >= 8'h80) ? {4'hF, f} : {4'h0, f};
  endfunction

  task automatic push_exp(string tag);
    exp_t e;
    e.addr = model_addr(bank_mode_i, fld_i);
    e.rb   = {4'h0, mdl_bank};
    e.tag  = tag;
    exp_q.push_back(e);
    -> drv_ev;
  endtask

  task automatic access(logic m, logic [7:0] f, string tag);
    @(negedge clk);
    bank_ld_i   = 1'b0;
    bank_mode_i = m;
    fld_i       = f;
    push_exp(tag);
  endtask

  // The load cycle itself is checked against the old bank (R5).
  task automatic load(logic [7:0] lit, logic [7:0] f);
    @(negedge clk);
    bank_ld_i   = 1'b1;
    bank_lit_i  = lit;
    bank_mode_i = 1'b1;
    fld_i       = f;
    push_exp("R5");
    @(posedge clk);
    mdl_bank = lit[3:0];
  endtask

  initial begin : monitor
    forever begin
      @(drv_ev);
      #1;
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (addr_o !== e.addr || bank_rb_o !== e.rb) begin
          errors++;
          $display("FAIL %s: addr=%h rb=%h expected addr=%h rb=%h",
                   e.tag, addr_o, bank_rb_o, e.addr, e.rb);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (bank_rb_o !== 8'h00) begin
      errors++;
      $display("FAIL R1: rb=%h expected 00", bank_rb_o);
    end
    @(negedge clk);
    rst_n = 1'b1;

    access(1'b1, 8'h10, "R1");
    access(1'b0, 8'h00, "R2");
    access(1'b0, 8'h7F, "R2");
    access(1'b0, 8'h80, "R3");
    access(1'b0, 8'hE8, "R3");
    access(1'b0, 8'hFF, "R3");
    load(8'h03, 8'h40);
    access(1'b1, 8'h40, "R4");
    access(1'b1, 8'h45, "R4");
    load(8'hA5, 8'h11);
    access(1'b1, 8'hFF, "R6");
    access(1'b0, 8'h20, "R8");
    access(1'b0, 8'hE8, "R8");
    repeat (4) @(posedge clk);
    access(1'b1, 8'h07, "R7");
    load(8'h0F, 8'h00);
    access(1'b1, 8'h00, "R4");
    access(1'b0, 8'h7F, "R8");
    load(8'hF0, 8'h33);
    access(1'b1, 8'h33, "R6");
    repeat (3) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule